// File: doc/BRIEF.md
# Processor Board Interrupt and Timer Control Register Unit

This block is the per-processor control/status register unit on a board of a small multiprocessor. It folds up to 32 interrupt request lines into one 32-bit control/status word (CSR), produces one combined processor interrupt whose changes are gated by an enable bit of that word, and runs a periodic timer. The timer raises a pending flag and a level timer interrupt that stays up until software writes the CSR. A second address window holds a byte-wide interrupt vector register that software reads back to learn the cause, for example 0xFC for a transmit event, 0xF8 for a receive event and 0x80 for an inter-processor event.

The register bus is byte addressed with separate read and write strobes. Address bit 12 selects the window. With it clear the access goes to the 4 KB CSR window, where only offset 0x000 holds the CSR. With it set the access goes to the vector window, and every offset there reaches the one vector register. Read data is registered and valid in the cycle after the read strobe. The `cpu_id` input tells the block which processor is accessing it.

Two small state machines carry the interrupt outputs. The timer machine has the states TMR_IDLE and TMR_PENDING. Its transition `arm` (TMR_IDLE to TMR_PENDING) fires on a prescaled timer event while the timer enable is set and no CSR write is under way. Its transition `ack` (TMR_PENDING to TMR_IDLE) fires on any CSR write. The processor interrupt machine has the states IRQ_LOW and IRQ_HIGH. Its transition `raise` (IRQ_LOW to IRQ_HIGH) fires when some request line rises while the enable bit is set. Its transition `drop` (IRQ_HIGH to IRQ_LOW) fires when some request line falls while the enable bit is clear. A prescaler turns every `TICK_DIV`-th `tick` strobe into one timer event.

Top module: `csr_intc`

## Requirements
- R1: After reset the CSR reads 0 apart from the ID field, the vector register reads 0, and `cpu_irq` and `timer_irq` are both 0.
- R2: Every read or write in the CSR window, at any offset, loads `cpu_id` into CSR bits [3:0]. A CSR read returns the `cpu_id` present during that read in bits [3:0].
- R3: A rising edge on `irq_lines[n]` sets CSR bit n and a falling edge clears it, for any n from 0 to 31.
- R4: `cpu_irq` goes from 0 to 1 only in the cycle after a rising edge on some request line while CSR bit 28 (interrupt enable) is 1. A rising edge while bit 28 is 0 leaves it at 0.
- R5: `cpu_irq` goes from 1 to 0 only in the cycle after a falling edge on some request line while CSR bit 28 is 0. A falling edge while bit 28 is 1 leaves it high, and writing bit 28 alone does not move it.
- R6: The prescaler turns every TICK_DIV-th `tick` strobe, counted from reset, into one timer event. The strobes in between do nothing.
- R7: A timer event while CSR bit 15 (timer enable) is 1 sets CSR bit 29 (timer pending) and `timer_irq`. Both stay at 1 through further events until acknowledged. With bit 15 at 0 an event changes nothing.
- R8: A write to CSR offset 0x000 loads the written word, with bits [3:0] replaced by `cpu_id`. It clears bit 29 and `timer_irq`. When a timer event falls in the same cycle, the write wins and bit 29 ends up 0.
- R9: Writes to CSR window offsets other than 0x000 leave the CSR unchanged, and reads of those offsets return 0.
- R10: In the vector window (address bit 12 = 1), a write at any offset stores `wdata[7:0]`. A read at any offset returns that byte zero-extended to 32 bits, and vector accesses leave the CSR unchanged.
- R11: CSR bit 16 reads as the stored bit XOR a status bit that toggles every clock, so two reads in consecutive cycles differ exactly in bit 16. `rdata` is valid in the cycle after `rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (13) | Byte address; bit 12 selects the vector window |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd` |
| cpu_id | input | 4 | ID of the accessing processor |
| irq_lines | input | 32 | Level interrupt request lines |
| tick | input | 1 | Timer tick strobe, one cycle wide |
| cpu_irq | output | 1 | Combined processor interrupt |
| timer_irq | output | 1 | Level timer interrupt |

## Verification
The assertions assume `rd` and `wr` are never high together and that the request lines are synchronous to `clk`, so each change produces exactly one edge. They also assume a timer event is judged against the enable bit as stored before the same cycle's write. The stimulus issues one bus operation per cycle and changes lines and `tick` only at the falling clock edge. Line edges and CSR writes are kept in separate cycles, except in the one case where the write-versus-timer priority is the point of the test. Ticks are issued in whole prescaler periods, so the count of timer events stays known.

// File: rtl/csr_intc_pkg.sv
`timescale 1ns/1ps
package csr_intc_pkg;
    localparam int CSR_W        = 32;
    localparam int ID_W         = 4;
    localparam int VEC_W        = 8;
    localparam int BIT_TMR_EN   = 15;
    localparam int BIT_JITTER   = 16;
    localparam int BIT_IRQ_EN   = 28;
    localparam int BIT_TMR_PEND = 29;

    typedef enum logic {
        TMR_IDLE    = 1'b0,
        TMR_PENDING = 1'b1
    } tmr_state_e;

    typedef enum logic {
        IRQ_LOW  = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_e;
endpackage

// File: rtl/csr_intc_prescale.sv
`timescale 1ns/1ps
module csr_intc_prescale #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic evt
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign evt = tick;
        end else begin : g_div
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (tick) begin
                    if (cnt_q == LAST) cnt_q <= '0;
                    else               cnt_q <= cnt_q + 1'b1;
                end
            end

            assign evt = tick && (cnt_q == LAST);

            AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST); // R6
            AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !tick |=> $stable(cnt_q)); // R6
        end
    endgenerate
endmodule

// File: rtl/csr_intc_edges.sv
`timescale 1ns/1ps
module csr_intc_edges #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign rise[i] = lines[i] & ~prev_q[i];
            assign fall[i] = ~lines[i] & prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/csr_intc_timer.sv
`timescale 1ns/1ps
module csr_intc_timer
    import csr_intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE:    if (evt && enable && !ack) state_d = TMR_PENDING; // arm
            TMR_PENDING: if (ack)                   state_d = TMR_IDLE;    // ack
            default:                                state_d = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == TMR_PENDING);
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !pending); // R8
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !ack |=> pending); // R7
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt && enable && !ack |=> pending); // R7
    AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && !(evt && enable) |=> !pending); // R7
endmodule

// File: rtl/csr_intc_cpuirq.sv
`timescale 1ns/1ps
module csr_intc_cpuirq
    import csr_intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_rise,
    input  logic any_fall,
    input  logic enable,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_LOW:  if (any_rise && enable)  state_d = IRQ_HIGH; // raise
            IRQ_HIGH: if (any_fall && !enable) state_d = IRQ_LOW;  // drop
            default:                           state_d = IRQ_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_HIGH);
    end

    AST_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(any_rise && enable)); // R4
    AST_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(any_fall && !enable)); // R5
endmodule

// File: rtl/csr_intc.sv
`timescale 1ns/1ps
module csr_intc
    import csr_intc_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [CSR_W-1:0]  wdata,
    output logic [CSR_W-1:0]  rdata,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic [CSR_W-1:0]  irq_lines,
    input  logic              tick,
    output logic              cpu_irq,
    output logic              timer_irq
);
    localparam int WIN_BIT = ADDR_W - 1;

    logic [CSR_W-1:0] csr_q, csr_d, csr_view;
    logic [VEC_W-1:0] vec_q;
    logic             jit_q;
    logic [CSR_W-1:0] rise, fall;
    logic             tmr_evt, pending;
    logic             in_csr_win, in_vec_win, csr_hit, csr_acc, csr_wr, vec_wr;

    always_comb begin
        in_vec_win = addr[WIN_BIT];
        in_csr_win = !addr[WIN_BIT];
        csr_hit    = in_csr_win && (addr[WIN_BIT-1:0] == '0);
        csr_acc    = (rd || wr) && in_csr_win;
        csr_wr     = wr && csr_hit;
        vec_wr     = wr && in_vec_win;
    end

    csr_intc_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .evt(tmr_evt)
    );

    csr_intc_edges #(.N(CSR_W)) u_edg (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .rise(rise), .fall(fall)
    );

    csr_intc_timer u_tmr (
        .clk(clk), .rst_n(rst_n), .evt(tmr_evt),
        .enable(csr_q[BIT_TMR_EN]), .ack(csr_wr), .pending(pending)
    );

    csr_intc_cpuirq u_irq (
        .clk(clk), .rst_n(rst_n), .any_rise(|rise), .any_fall(|fall),
        .enable(csr_q[BIT_IRQ_EN]), .irq(cpu_irq)
    );

    always_comb begin
        if (csr_wr) begin
            csr_d               = wdata;
            csr_d[BIT_TMR_PEND] = 1'b0;
        end else begin
            csr_d = (csr_q | rise) & ~fall;
        end
        if (csr_acc) csr_d[ID_W-1:0] = cpu_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
            vec_q <= '0;
            jit_q <= 1'b0;
        end else begin
            csr_q <= csr_d;
            jit_q <= ~jit_q;
            if (vec_wr) vec_q <= wdata[VEC_W-1:0];
        end
    end

    always_comb begin
        csr_view                 = csr_q;
        csr_view[ID_W-1:0]       = cpu_id;
        csr_view[BIT_TMR_PEND]   = csr_q[BIT_TMR_PEND] | pending;
        csr_view[BIT_JITTER]     = csr_q[BIT_JITTER] ^ jit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            if (in_vec_win)   rdata <= {{(CSR_W-VEC_W){1'b0}}, vec_q};
            else if (csr_hit) rdata <= csr_view;
            else              rdata <= '0;
        end
    end

    always_comb begin
        timer_irq = pending;
    end

    AST_ID_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        csr_acc |=> csr_q[ID_W-1:0] == $past(cpu_id)); // R2
    AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr && in_csr_win && !csr_hit && rise == '0 && fall == '0
        |=> $stable(csr_q[CSR_W-1:ID_W])); // R9
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wr |=> $stable(vec_q)); // R10
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr)); // R11
    AST_TMR_BIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> csr_view[BIT_TMR_PEND]); // R7
endmodule

// File: tb/sim_csr_intc.sv
`timescale 1ns/1ps
module sim_csr_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  cpu_id = '0;
    logic [31:0] irq_lines = '0;
    logic        tick = 1'b0;
    logic        cpu_irq, timer_irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic        done = 1'b0;

    localparam logic [31:0] JMASK = 32'hFFFE_FFFF;

    always #2.5 clk = ~clk;

    csr_intc u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .cpu_id(cpu_id),
        .irq_lines(irq_lines), .tick(tick),
        .cpu_irq(cpu_irq), .timer_irq(timer_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares each read result with the queued expectation
    always @(posedge clk) rd_seen <= rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-underflow", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rdata & JMASK, e & JMASK);
            end
        end
    end

    task automatic do_write(input logic [12:0] a, input logic [31:0] d, input logic [3:0] id);
        @(negedge clk);
        addr = a; wdata = d; cpu_id = id; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [12:0] a, input logic [3:0] id,
                           input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; cpu_id = id; rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic set_lines(input logic [31:0] v);
        @(negedge clk); irq_lines = v;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            check("watchdog", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r1, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
        check("R1 timer_irq", {31'd0, timer_irq}, 32'd0);
        do_read(13'h000, 4'h0, 32'h0, "R1 csr");
        do_read(13'h1000, 4'h0, 32'h0, "R1 vector");
        // R2 id forcing
        do_read(13'h000, 4'hA, 32'h0000_000A, "R2 id A");
        do_read(13'h000, 4'h5, 32'h0000_0005, "R2 id 5");
        // R8 write load with id substitution
        do_write(13'h000, 32'h0000_0F0F, 4'h3);
        do_read(13'h000, 4'h3, 32'h0000_0F03, "R8 load");
        // R9 other offsets
        do_write(13'h004, 32'hFFFF_FFFF, 4'h3);
        do_read(13'h004, 4'h3, 32'h0, "R9 read other");
        do_read(13'h000, 4'h3, 32'h0000_0F03, "R9 csr untouched");
        do_write(13'h000, 32'h0, 4'h0);
        // R3 / R4 / R5
        set_lines(32'h0000_0020);
        check("R4 gated raise", {31'd0, cpu_irq}, 32'd0);
        do_read(13'h000, 4'h0, 32'h0000_0020, "R3 set bit5");
        do_write(13'h000, 32'h1000_0000, 4'h0);
        set_lines(32'h0000_00A0);
        check("R4 raise", {31'd0, cpu_irq}, 32'd1);
        do_read(13'h000, 4'h0, 32'h1000_0080, "R3 set bit7");
        set_lines(32'h0000_0020);
        check("R5 hold while enabled", {31'd0, cpu_irq}, 32'd1);
        do_read(13'h000, 4'h0, 32'h1000_0000, "R3 clear bit7");
        do_write(13'h000, 32'h0, 4'h0);
        check("R5 write alone no drop", {31'd0, cpu_irq}, 32'd1);
        set_lines(32'h0);
        check("R5 drop", {31'd0, cpu_irq}, 32'd0);
        set_lines(32'h8000_0000);
        do_read(13'h000, 4'h0, 32'h8000_0000, "R3 set bit31");
        set_lines(32'h0);
        do_read(13'h000, 4'h0, 32'h0, "R3 clear bit31");
        // R6 / R7 timer
        do_write(13'h000, 32'h0000_8000, 4'h0);
        do_tick();
        check("R6 first tick no event", {31'd0, timer_irq}, 32'd0);
        do_tick();
        check("R7 pending set", {31'd0, timer_irq}, 32'd1);
        do_read(13'h000, 4'h0, 32'h2000_8000, "R7 bit29");
        do_tick(); do_tick();
        check("R7 level held", {31'd0, timer_irq}, 32'd1);
        do_read(13'h000, 4'h0, 32'h2000_8000, "R7 still pending");
        do_write(13'h000, 32'h0000_8000, 4'h0);
        check("R8 ack", {31'd0, timer_irq}, 32'd0);
        do_read(13'h000, 4'h0, 32'h0000_8000, "R8 bit29 clear");
        // R8 write vs event in same cycle
        do_tick();
        @(negedge clk);
        addr = 13'h000; wdata = 32'h0000_8000; cpu_id = 4'h0; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        check("R8 write wins", {31'd0, timer_irq}, 32'd0);
        do_read(13'h000, 4'h0, 32'h0000_8000, "R8 write wins csr");
        do_tick(); do_tick();
        check("R6 period kept", {31'd0, timer_irq}, 32'd1);
        do_write(13'h000, 32'h0, 4'h0);
        do_tick(); do_tick();
        check("R7 disabled", {31'd0, timer_irq}, 32'd0);
        do_read(13'h000, 4'h0, 32'h0, "R7 disabled csr");
        // R10 vector window
        do_write(13'h1000, 32'h0000_00FC, 4'h0);
        do_read(13'h1000, 4'h0, 32'h0000_00FC, "R10 transmit code");
        do_write(13'h1080, 32'h0000_00F8, 4'h0);
        do_read(13'h1000, 4'h0, 32'h0000_00F8, "R10 any offset");
        do_write(13'h1FFC, 32'hFFFF_FF80, 4'h0);
        do_read(13'h1010, 4'h0, 32'h0000_0080, "R10 byte only");
        do_read(13'h000, 4'h0, 32'h0, "R10 csr untouched");
        // R11 jitter bit and read latency
        do_write(13'h000, 32'h0001_0000, 4'h0);
        @(negedge clk);
        addr = 13'h000; cpu_id = 4'h0; rd = 1'b1;
        exp_q.push_back(32'h0001_0000); tag_q.push_back("R11 read a");
        @(negedge clk);
        r1 = rdata;
        exp_q.push_back(32'h0001_0000); tag_q.push_back("R11 read b");
        @(negedge clk);
        r2 = rdata;
        rd = 1'b0;
        check("R11 bit16 toggles", r1 ^ r2, 32'h0001_0000);
        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule